// File: doc/BRIEF.md
# Multi-Thread Event Performance Counter

This block counts microarchitectural events for a core that runs several hardware threads. Two programmable 24-bit counters each take an event id and a thread mask. A third, fixed counter sits at the last index and counts active cycles of the threads it selects. Every cycle the core presents one pulse bit per event per thread. A programmable counter adds the number of selected threads that raised its event in that cycle. Events flagged in a global-event parameter mask are summed over every thread, whatever the mask says.

Software reaches the block through a flat single-cycle register port with no back-pressure. A write takes effect at the next clock edge, and a read returns combinationally from the current address. Software sets a sampling period by preloading a counter with 2^24 minus the period. When a counter carries past 0xFFFFFF it sets a sticky overflow flag, and an interrupt is raised if that flag is enabled. A revision parameter selects the write behaviour: on newer cores a count write preloads the written value, and on older cores it only clears the counter.

Top module: `pmu_event_counters`

## Requirements
- R1: Counter indices 0 and 1 are programmable event counters and index 2 is a cycle counter. Index 2 adds, each enabled cycle, the number of threads that are both active and selected in its thread mask. All three counters are CNT_W (24) bits wide and reset to 0.
- R2: When an enabled counter's increment carries past 2^24-1, the counter keeps the sum modulo 2^24 and sets its overflow status bit. For example, 0xFFFFFF plus 1 gives 0 and 0xFFFFFE plus 3 gives 1.
- R3: For an event whose GLOBAL_EVENT_MASK bit is 0, the increment is the count of threads t with ev_pulse_i[e*NUM_THREADS+t] set and select bit t set. A mask of 0 gives no count.
- R4: For an event whose GLOBAL_EVENT_MASK bit is 1, the increment is the count of all threads pulsing that event, regardless of the thread mask.
- R5: A count write with WRITE_PRELOAD=1 loads reg_wdata_i[23:0]. With WRITE_PRELOAD=0, any count write sets the counter to 0.
- R6: A count write in the same cycle as an increment wins, and the increment for that counter is dropped.
- R7: A counter whose enable bit is 0 holds its value whatever the pulses are.
- R8: Reading a count returns its 24-bit value zero-extended to 32 bits. A read changes no state.
- R9: Register map (byte addresses, index i = 0..2), with reset value 0 and unmapped reads returning 0:
  - count at 0x00+8i;
  - config at 0x20+8i, holding the event id in bits [EV_W-1:0] and the enable in bit 31;
  - thread mask at 0x40+8i, in bits [NUM_THREADS-1:0];
  - overflow status at 0x60, bit i per counter, write-1-to-clear;
  - interrupt enable at 0x68, bit i.
- R10: irq_o is high while any status bit is set together with its enable bit. Status bits stay set until cleared by writing 1. A new overflow in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse_i | input | NUM_EVENTS*NUM_THREADS | Event pulses, bit e*NUM_THREADS+t is event e on thread t |
| thr_active_i | input | NUM_THREADS | Per-thread active flag for the cycle counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench sweeps all sixteen thread masks against sixteen pulse patterns per mask. A design that counted only one thread per cycle, or ignored the mask, would drift from the model, and so would one that applied the mask to the global event. It lands counters exactly on 0xFFFFFF and on 0xFFFFFE with a multi-thread increment. A design that tested equality instead of carry would miss the wrap flag. It collides a count write with a full set of pulses, and a status clear with a fresh overflow. Dropping the write or letting the clear win would show up there. A second instance built for the older revision must read 0 after a nonzero write.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned NUM_IDX = 3;
  localparam int unsigned CYC_IDX = NUM_IDX - 1;
  localparam int unsigned CFG_EN_BIT = 31;
  localparam logic [1:0] BANK_COUNT = 2'd0;
  localparam logic [1:0] BANK_CFG   = 2'd1;
  localparam logic [1:0] BANK_SEL   = 2'd2;
  localparam logic [1:0] BANK_CTRL  = 2'd3;
  localparam logic [1:0] SLOT_STATUS = 2'd0;
  localparam logic [1:0] SLOT_IEN    = 2'd1;
endpackage

// File: rtl/pmu_event_select.sv
module pmu_event_select #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_EVENTS = 16,
  parameter int unsigned EV_W = 4,
  parameter int unsigned INC_W = 3,
  parameter logic [NUM_EVENTS-1:0] GLOBAL_EVENT_MASK = '0,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_EVENTS*NUM_THREADS-1:0] ev_pulse_i,
  input  logic [NUM_THREADS-1:0]          active_i,
  input  logic [EV_W-1:0]                 ev_id_i,
  input  logic [NUM_THREADS-1:0]          sel_i,
  output logic [INC_W-1:0]                inc_o
);
  logic [NUM_THREADS-1:0] row;
  logic [NUM_THREADS-1:0] hits;
  logic                   glob;

  // Pick the pulse row of the chosen event without a variable part-select.
  always_comb begin
    row  = '0;
    glob = 1'b0;
    for (int e = 0; e < int'(NUM_EVENTS); e++) begin
      if (ev_id_i == EV_W'(e)) begin
        row  = ev_pulse_i[e*NUM_THREADS +: NUM_THREADS];
        glob = GLOBAL_EVENT_MASK[e];
      end
    end
  end

  always_comb begin
    if (IS_CYCLE) hits = active_i & sel_i;
    else if (glob) hits = row;
    else hits = row & sel_i;
  end

  always_comb begin
    inc_o = '0;
    for (int t = 0; t < int'(NUM_THREADS); t++) inc_o = inc_o + INC_W'(hits[t]);
  end

  p_inc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inc_o) <= int'(NUM_THREADS));
  p_unsel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_CYCLE && sel_i == '0 && !glob) |-> inc_o == '0);
  p_cyc_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_CYCLE && active_i == '0) |-> inc_o == '0);
endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned INC_W = 3,
  parameter bit WRITE_PRELOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W:0]   sum;

  generate
    if (WRITE_PRELOAD) begin : g_preload
      assign load_val = wdata_i;
    end else begin : g_clear_only
      logic unused_wdata;
      assign unused_wdata = ^wdata_i;
      assign load_val = '0;
    end
  endgenerate

  assign sum    = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
  assign wrap_o = en_i && !wr_i && sum[CNT_W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_i) cnt_q <= load_val;
    else if (en_i) cnt_q <= sum[CNT_W-1:0];
  end

  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_i) |=> $stable(cnt_q));
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cnt_q == (WRITE_PRELOAD ? $past(wdata_i) : CNT_W'(0)));
  p_wrap_lands_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q < CNT_W'($past(inc_i)));
  p_no_wrap_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wr_i && !wrap_o) |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/pmu_event_counters.sv
module pmu_event_counters
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_EVENTS = 16,
  parameter int unsigned CNT_W = 24,
  parameter logic [NUM_EVENTS-1:0] GLOBAL_EVENT_MASK = 16'hC000,
  parameter bit WRITE_PRELOAD = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_EVENTS*NUM_THREADS-1:0] ev_pulse_i,
  input  logic [NUM_THREADS-1:0]            thr_active_i,
  input  logic                              reg_wr_i,
  input  logic [7:0]                        reg_addr_i,
  input  logic [31:0]                       reg_wdata_i,
  output logic [31:0]                       reg_rdata_o,
  output logic                              irq_o
);
  localparam int unsigned EV_W  = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
  localparam int unsigned INC_W = $clog2(NUM_THREADS + 1);

  logic [EV_W-1:0]        ev_q   [NUM_IDX];
  logic [NUM_THREADS-1:0] sel_q  [NUM_IDX];
  logic [NUM_IDX-1:0]     en_q;
  logic [NUM_IDX-1:0]     ien_q;
  logic [NUM_IDX-1:0]     status_q;
  logic [NUM_IDX-1:0]     wrap;
  logic [NUM_IDX-1:0]     cnt_wr;
  logic [NUM_IDX-1:0]     st_clr;
  logic [CNT_W-1:0]       cnt    [NUM_IDX];
  logic [INC_W-1:0]       inc    [NUM_IDX];

  logic       aligned;
  logic [1:0] bank;
  logic [1:0] slot;
  logic       unused_wdata;

  assign aligned = !reg_addr_i[7] && (reg_addr_i[2:0] == 3'b000);
  assign bank    = reg_addr_i[6:5];
  assign slot    = reg_addr_i[4:3];
  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    for (int i = 0; i < int'(NUM_IDX); i++)
      cnt_wr[i] = reg_wr_i && aligned && bank == BANK_COUNT && slot == 2'(i);
    st_clr = (reg_wr_i && aligned && bank == BANK_CTRL && slot == SLOT_STATUS)
             ? reg_wdata_i[NUM_IDX-1:0] : '0;
  end

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_IDX); i++) begin
        ev_q[i]  <= '0;
        sel_q[i] <= '0;
      end
      en_q  <= '0;
      ien_q <= '0;
    end else if (reg_wr_i && aligned) begin
      for (int i = 0; i < int'(NUM_IDX); i++) begin
        if (bank == BANK_CFG && slot == 2'(i)) begin
          ev_q[i] <= reg_wdata_i[EV_W-1:0];
          en_q[i] <= reg_wdata_i[CFG_EN_BIT];
        end
        if (bank == BANK_SEL && slot == 2'(i)) sel_q[i] <= reg_wdata_i[NUM_THREADS-1:0];
      end
      if (bank == BANK_CTRL && slot == SLOT_IEN) ien_q <= reg_wdata_i[NUM_IDX-1:0];
    end
  end

  // Sticky overflow flags: a fresh wrap outranks a clear.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else status_q <= (status_q & ~st_clr) | wrap;
  end

  assign irq_o = |(status_q & ien_q);

  generate
    for (genvar i = 0; i < int'(NUM_IDX); i++) begin : g_idx
      pmu_event_select #(
        .NUM_THREADS(NUM_THREADS), .NUM_EVENTS(NUM_EVENTS), .EV_W(EV_W),
        .INC_W(INC_W), .GLOBAL_EVENT_MASK(GLOBAL_EVENT_MASK),
        .IS_CYCLE(i == int'(CYC_IDX))
      ) u_sel (
        .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev_pulse_i), .active_i(thr_active_i),
        .ev_id_i(ev_q[i]), .sel_i(sel_q[i]), .inc_o(inc[i])
      );
      pmu_counter_slice #(
        .CNT_W(CNT_W), .INC_W(INC_W), .WRITE_PRELOAD(WRITE_PRELOAD)
      ) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(en_q[i]), .wr_i(cnt_wr[i]),
        .wdata_i(reg_wdata_i[CNT_W-1:0]), .inc_i(inc[i]), .cnt_o(cnt[i]), .wrap_o(wrap[i])
      );

      p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !(reg_wr_i && reg_addr_i == 8'h60 && reg_wdata_i[i])) |=> status_q[i]);
      p_wrap_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> status_q[i]);
    end
  endgenerate

  // Read path, free of side effects.
  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      case (bank)
        BANK_COUNT: if (int'(slot) < int'(NUM_IDX)) reg_rdata_o = 32'(cnt[slot]);
        BANK_CFG: if (int'(slot) < int'(NUM_IDX)) begin
          reg_rdata_o[EV_W-1:0]   = ev_q[slot];
          reg_rdata_o[CFG_EN_BIT] = en_q[slot];
        end
        BANK_SEL: if (int'(slot) < int'(NUM_IDX)) reg_rdata_o[NUM_THREADS-1:0] = sel_q[slot];
        default: begin
          if (slot == SLOT_STATUS) reg_rdata_o[NUM_IDX-1:0] = status_q;
          else if (slot == SLOT_IEN) reg_rdata_o[NUM_IDX-1:0] = ien_q;
        end
      endcase
    end
  end

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/pmu_event_counters_tb.sv
`timescale 1ns/1ps
module pmu_event_counters_tb_top;
  localparam int T = 4;
  localparam int E = 4;
  localparam logic [3:0] GMASK = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic [3:0]  act = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_old;
  logic        irq, irq_old;

  int n_chk = 0;
  int n_fail = 0;

  int          m_ev  [3];
  logic [3:0]  m_sel [3];
  logic [23:0] m_cnt [3];
  logic [2:0]  m_en, m_st, m_ien;

  always #5 clk = ~clk;

  pmu_event_counters #(.NUM_THREADS(T), .NUM_EVENTS(E), .CNT_W(24),
    .GLOBAL_EVENT_MASK(GMASK), .WRITE_PRELOAD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev), .thr_active_i(act), .reg_wr_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  pmu_event_counters #(.NUM_THREADS(T), .NUM_EVENTS(E), .CNT_W(24),
    .GLOBAL_EVENT_MASK(GMASK), .WRITE_PRELOAD(1'b0)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev), .thr_active_i(act), .reg_wr_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_old), .irq_o(irq_old));

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  function automatic int model_inc(int i, logic [15:0] p, logic [3:0] a);
    logic [3:0] row, h;
    if (i == 2) h = a & m_sel[2];
    else begin
      row = p[m_ev[i]*4 +: 4];
      h = GMASK[m_ev[i]] ? row : (row & m_sel[i]);
    end
    return $countones(h);
  endfunction

  // One clock cycle of stimulus plus the matching model update.
  task automatic cyc(bit w, logic [7:0] a, logic [31:0] d, logic [15:0] p, logic [3:0] ac);
    logic [2:0] wr_mask = '0;
    logic [2:0] clr = '0;
    logic [24:0] s;
    @(negedge clk);
    we = w; addr = a; wdata = d; ev = p; act = ac;
    for (int i = 0; i < 3; i++) begin
      if (w && a == 8'(8*i)) m_cnt[i] = d[23:0];
      else if (m_en[i]) begin
        s = {1'b0, m_cnt[i]} + 25'(model_inc(i, p, ac));
        if (s[24]) wr_mask[i] = 1'b1;
        m_cnt[i] = s[23:0];
      end
    end
    if (w && a == 8'h60) clr = d[2:0];
    m_st = (m_st & ~clr) | wr_mask;
    for (int i = 0; i < 3; i++) begin
      if (w && a == 8'(8'h20 + 8*i)) begin m_ev[i] = int'(d[1:0]); m_en[i] = d[31]; end
      if (w && a == 8'(8'h40 + 8*i)) m_sel[i] = d[3:0];
    end
    if (w && a == 8'h68) m_ien = d[2:0];
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    we = 1'b0; addr = a; ev = '0; act = '0;
    #1 v = rdata;
  endtask

  initial begin
    logic [31:0] v, v2;
    for (int i = 0; i < 3; i++) begin m_ev[i] = 0; m_sel[i] = '0; m_cnt[i] = '0; end
    m_en = '0; m_st = '0; m_ien = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R9, R1)
    for (int i = 0; i < 3; i++) begin
      rd(8'(8*i), v); chk("R1 reset count", v, 32'h0);
    end
    rd(8'h60, v); chk("R9 reset status", v, 32'h0);
    #1 chk("R10 reset irq", {31'b0, irq}, 32'h0);

    // Disabled counters hold (R7)
    cyc(1, 8'h40, 32'hF, 16'h0, 4'h0);
    repeat (4) cyc(0, 8'h0, 32'h0, 16'hFFFF, 4'hF);
    rd(8'h00, v); chk("R7 disabled holds", v, 32'h0);

    // Configure: ctr0 event1, ctr1 global event3 mask t0, ctr2 cycles
    cyc(1, 8'h20, 32'h8000_0001, 16'h0, 4'h0);
    cyc(1, 8'h28, 32'h8000_0003, 16'h0, 4'h0);
    cyc(1, 8'h30, 32'h8000_0000, 16'h0, 4'h0);
    cyc(1, 8'h48, 32'h1, 16'h0, 4'h0);
    rd(8'h20, v); chk("R9 config readback", v, 32'h8000_0001);
    rd(8'h28, v); chk("R9 config readback", v, 32'h8000_0003);
    rd(8'h48, v); chk("R9 select readback", v, 32'h1);
    rd(8'h18, v); chk("R9 unmapped reads zero", v, 32'h0);

    // Sweep every thread mask against sixteen pulse patterns (R3, R4, R1)
    for (int s = 0; s < 16; s++) begin
      cyc(1, 8'h40, 32'(s), 16'h0, 4'h0);
      cyc(1, 8'h50, 32'(s), 16'h0, 4'h0);
      for (int k = 0; k < 16; k++) begin
        logic [3:0] kk = 4'(k);
        cyc(0, 8'h0, 32'h0, {4'(kk * 4'd5), kk, ~kk, kk ^ 4'h5}, kk ^ 4'(s));
      end
      rd(8'h00, v); chk("R3 masked sum", v, {8'h0, m_cnt[0]});
      rd(8'h08, v); chk("R4 global sum", v, {8'h0, m_cnt[1]});
      rd(8'h10, v); chk("R1 cycle sum", v, {8'h0, m_cnt[2]});
    end

    // Wrap with a multi-thread increment (R2)
    cyc(1, 8'h00, 32'h00FF_FFFE, 16'h0, 4'h0);
    cyc(1, 8'h40, 32'hF, 16'h0, 4'h0);
    cyc(0, 8'h0, 32'h0, 16'h00E0, 4'h0);
    rd(8'h00, v); chk("R2 wrap value", v, 32'h1);
    rd(8'h60, v); chk("R2 wrap flag", v & 32'h1, 32'h1);
    #1 chk("R10 irq masked", {31'b0, irq}, 32'h0);
    cyc(1, 8'h68, 32'h1, 16'h0, 4'h0);
    rd(8'h68, v); chk("R9 ien readback", v, 32'h1);
    #1 chk("R10 irq raised", {31'b0, irq}, 32'h1);
    cyc(1, 8'h60, 32'h0, 16'h0, 4'h0);
    rd(8'h60, v); chk("R10 sticky on zero write", v & 32'h1, 32'h1);
    cyc(1, 8'h60, 32'h1, 16'h0, 4'h0);
    rd(8'h60, v); chk("R10 w1c clears", v & 32'h1, 32'h0);
    #1 chk("R10 irq drops", {31'b0, irq}, 32'h0);

    // Exact 0xFFFFFF to 0 and zero-extended read (R2, R8)
    cyc(1, 8'h00, 32'h00FF_FFFF, 16'h0, 4'h0);
    rd(8'h00, v); chk("R8 zero-extended", v, 32'h00FF_FFFF);
    cyc(0, 8'h0, 32'h0, 16'h0010, 4'h0);
    rd(8'h00, v); chk("R2 wrap to zero", v, 32'h0);
    rd(8'h60, v); chk("R2 flag on exact wrap", v & 32'h1, 32'h1);

    // New overflow beats a same-cycle clear (R10)
    cyc(1, 8'h08, 32'h00FF_FFFF, 16'h0, 4'h0);
    cyc(1, 8'h60, 32'h2, 16'h1000, 4'h0);
    rd(8'h60, v); chk("R10 set beats clear", v & 32'h2, 32'h2);

    // Write beats increment; upper write bits dropped (R6, R5)
    cyc(1, 8'h00, 32'hABCD_EF12, 16'hFFFF, 4'hF);
    rd(8'h00, v); chk("R6 write wins", v, 32'h00CD_EF12);
    rd(8'h08, v); chk("R6 neighbour still counts", v, {8'h0, m_cnt[1]});

    // Disable ctr0, reads have no side effect (R7, R8)
    cyc(1, 8'h20, 32'h1, 16'h0, 4'h0);
    repeat (3) cyc(0, 8'h0, 32'h0, 16'hFFFF, 4'hF);
    rd(8'h00, v); chk("R7 hold after disable", v, 32'h00CD_EF12);
    rd(8'h00, v2); chk("R8 repeat read", v2, v);

    // Older revision clears on write (R5)
    cyc(1, 8'h08, 32'h0012_3456, 16'h0, 4'h0);
    rd(8'h08, v); chk("R5 preload", v, 32'h0012_3456);
    chk("R5 clear-only revision", rdata_old, 32'h0);

    for (int i = 0; i < 3; i++) begin
      rd(8'(8*i), v); chk("R1 final model match", v, {8'h0, m_cnt[i]});
    end
    rd(8'h60, v); chk("R10 final status", v, {29'b0, m_st});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule